// File: doc/BRIEF.md
# Grouped Edge-Triggered Interrupt Collector

This block collects four event sources of a power-management style device and turns them into interrupts for a host. The sources are two current-sink events and two real-time-clock events: a periodic tick and an alarm. Each source first passes through a two-stage synchronizer. A rising edge of the synchronized value sets a sticky status bit, and that bit stays set until the host writes a one to it.

Each status bit has a mask bit beside it. A set mask bit means the source is masked. The status bits fall into two groups. The RTC group has the periodic and alarm bits, and the current-sink group has sink 1 and sink 2. Each group drives one primary line, which is high when any unmasked bit of that group is set. The single host interrupt is the OR of the two primary lines. Firmware can read the primary lines from a summary register to see which group needs service. It then reads that group's status register, services the event and clears the bits it handled.

The register port is a plain synchronous strobe interface. Writes take effect on the clock edge where the write strobe is high. Read data is combinational from the address while the read strobe is high, and it is zero while the read strobe is low. The block has no state machine. All state is per-bit sticky flags, mask flags and synchronizer flops.

Top module: `irq_aggregator`

## Requirements
- R1: A status bit is set only by a low-to-high transition of its synchronized source. A source held high does not set the bit again after the bit has been cleared.
- R2: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R3: If a rising edge and a write-1-clear reach the same status bit in the same cycle, the bit ends up set.
- R4: After reset every mask bit is 1. The mask register at 0x4019 reads 0x0C, the one at 0x401A reads 0xC0, and `irq_out` is 0.
- R5: A masked source still sets its status bit, and the bit reads back as set. A masked source never drives its primary line or `irq_out`.
- R6: The RTC primary line is the OR of the unmasked bits of the status register at 0x4011: bit 3 (periodic, source input 3) and bit 2 (alarm, source input 2). Their masks are the same bit positions at 0x4019.
- R7: The current-sink primary line is the OR of the unmasked bits of the status register at 0x4012: bit 7 (sink 2, source input 1) and bit 6 (sink 1, source input 0). Their masks are the same bit positions at 0x401A.
- R8: `irq_out` is the OR of the two primary lines. The summary register at 0x4010 shows the RTC line in bit 0 and the current-sink line in bit 1.
- R9: Register bits with no function read as 0 and ignore writes. An unmapped address reads 0. `rdata` is 0 while `rd_en` is low.
- R10: A source that rises before clock edge k shows in its status bit from edge k+2 onward, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 4 | Raw event sources: 0 sink 1, 1 sink 2, 2 RTC alarm, 3 RTC periodic |
| addr | input | 16 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational while rd_en is high |
| irq_out | output | 1 | Host interrupt |

## Verification
The bench targets these corner cases:

- Events that arrive while their source is masked. A design that gated capture with the mask would read back 0 for these events.
- A source held high across a clear. A level-sensitive design would set the bit again at once.
- A clear that lands in the same cycle as a new edge. A design that gave the clear priority would lose the event.
- The exact two-edge latency from a source rising to its status bit being set. An extra or missing pipeline stage moves the set by one cycle, and the bench checks both sides of that edge.
- Writes of all ones to the mask and status registers. These check that bits with no function stay 0 and that each mask steers only its own group's primary line.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int NSRC = 4;
    localparam int GRP_W = 2;

    localparam logic [AW-1:0] A_PRIMARY = 16'h4010;
    localparam logic [AW-1:0] A_STAT_RTC = 16'h4011;
    localparam logic [AW-1:0] A_STAT_CS = 16'h4012;
    localparam logic [AW-1:0] A_MASK_RTC = 16'h4019;
    localparam logic [AW-1:0] A_MASK_CS = 16'h401A;

    localparam int B_RTC_ALM = 2;
    localparam int B_RTC_PER = 3;
    localparam int B_CS1 = 6;
    localparam int B_CS2 = 7;

    localparam int P_RTC = 0;
    localparam int P_CS = 1;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] rise
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic         stat_wr,
    input  logic         mask_wr,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         primary
);
    logic [W-1:0] clr;

    assign clr = stat_wr ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask <= '1;
        end else begin
            status <= (status & ~clr) | set_pulse;
            if (mask_wr) begin
                mask <= wbits;
            end
        end
    end

    assign primary = |(status & ~mask);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    src_in,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          irq_out
);
    logic [NSRC-1:0]  edge_pulse;
    logic [GRP_W-1:0] cs_stat, cs_mask, rtc_stat, rtc_mask;
    logic [GRP_W-1:0] cs_wbits, rtc_wbits;
    logic             cs_line, rtc_line;
    logic [NSRC-1:0]  stat_v, mask_v;
    logic [DW-1:0]    rd_mux;

    irq_edge_sync #(.N(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(src_in), .rise(edge_pulse)
    );

    assign cs_wbits = {wdata[B_CS2], wdata[B_CS1]};
    assign rtc_wbits = {wdata[B_RTC_PER], wdata[B_RTC_ALM]};

    irq_group #(.W(GRP_W)) u_cs (
        .clk(clk), .rst_n(rst_n),
        .set_pulse(edge_pulse[1:0]),
        .stat_wr(wr_en && addr == A_STAT_CS),
        .mask_wr(wr_en && addr == A_MASK_CS),
        .wbits(cs_wbits),
        .status(cs_stat), .mask(cs_mask), .primary(cs_line)
    );

    irq_group #(.W(GRP_W)) u_rtc (
        .clk(clk), .rst_n(rst_n),
        .set_pulse(edge_pulse[3:2]),
        .stat_wr(wr_en && addr == A_STAT_RTC),
        .mask_wr(wr_en && addr == A_MASK_RTC),
        .wbits(rtc_wbits),
        .status(rtc_stat), .mask(rtc_mask), .primary(rtc_line)
    );

    assign stat_v = {rtc_stat, cs_stat};
    assign mask_v = {rtc_mask, cs_mask};

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            A_PRIMARY: begin
                rd_mux[P_RTC] = rtc_line;
                rd_mux[P_CS] = cs_line;
            end
            A_STAT_RTC: begin
                rd_mux[B_RTC_ALM] = rtc_stat[0];
                rd_mux[B_RTC_PER] = rtc_stat[1];
            end
            A_STAT_CS: begin
                rd_mux[B_CS1] = cs_stat[0];
                rd_mux[B_CS2] = cs_stat[1];
            end
            A_MASK_RTC: begin
                rd_mux[B_RTC_ALM] = rtc_mask[0];
                rd_mux[B_RTC_PER] = rtc_mask[1];
            end
            A_MASK_CS: begin
                rd_mux[B_CS1] = cs_mask[0];
                rd_mux[B_CS2] = cs_mask[1];
            end
            default: rd_mux = '0;
        endcase
    end

    assign rdata = rd_en ? rd_mux : '0;
    assign irq_out = rtc_line | cs_line;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          wr_en,
    input logic          irq_out,
    input logic [3:0]    edge_pulse,
    input logic [3:0]    stat_v,
    input logic [3:0]    mask_v
);
    logic [3:0] clr;

    assign clr[0] = wr_en && addr == A_STAT_CS && wdata[B_CS1];
    assign clr[1] = wr_en && addr == A_STAT_CS && wdata[B_CS2];
    assign clr[2] = wr_en && addr == A_STAT_RTC && wdata[B_RTC_ALM];
    assign clr[3] = wr_en && addr == A_STAT_RTC && wdata[B_RTC_PER];

    // R1 / R3: an edge always leaves its bit set, even against a clear
    p_set_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_pulse) |=> ((stat_v & $past(edge_pulse)) == $past(edge_pulse)));

    // R2: a clear without a competing edge empties the bit
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~edge_pulse)) |=> ((stat_v & $past(clr & ~edge_pulse)) == 4'b0));

    // R2: no edge and no clear keeps status steady
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse == 4'b0 && clr == 4'b0) |=> $stable(stat_v));

    // R5: everything masked keeps the host line quiet
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_v) |-> !irq_out);

    // R8: host line only with some unmasked set bit
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|(stat_v & ~mask_v)));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .irq_out(irq_out), .edge_pulse(edge_pulse), .stat_v(stat_v), .mask_v(mask_v)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 30;
    // kind: 0 = drive sources and wait, 1 = write, 2 = read compare, 3 = irq compare
    localparam logic [37:0] VEC [NV] = '{
        {2'd2, 4'h0, 16'h4019, 8'h00, 8'h0C}, // R4
        {2'd2, 4'h0, 16'h401A, 8'h00, 8'hC0}, // R4
        {2'd0, 4'h1, 16'h0000, 8'h00, 8'h00},
        {2'd2, 4'h0, 16'h4012, 8'h00, 8'h40}, // R5 latched while masked
        {2'd3, 4'h0, 16'h0000, 8'h00, 8'h00}, // R5 no irq
        {2'd1, 4'h0, 16'h401A, 8'h80, 8'h00},
        {2'd2, 4'h0, 16'h401A, 8'h00, 8'h80}, // R7 mask readback
        {2'd3, 4'h0, 16'h0000, 8'h00, 8'h01}, // R7 irq
        {2'd2, 4'h0, 16'h4010, 8'h00, 8'h02}, // R8 summary
        {2'd1, 4'h0, 16'h4012, 8'h00, 8'h00},
        {2'd2, 4'h0, 16'h4012, 8'h00, 8'h40}, // R2 write 0
        {2'd1, 4'h0, 16'h4012, 8'h40, 8'h00},
        {2'd2, 4'h0, 16'h4012, 8'h00, 8'h00}, // R2 clear
        {2'd3, 4'h0, 16'h0000, 8'h00, 8'h00}, // R8
        {2'd0, 4'h1, 16'h0000, 8'h00, 8'h00},
        {2'd2, 4'h0, 16'h4012, 8'h00, 8'h00}, // R1 held level
        {2'd0, 4'h4, 16'h0000, 8'h00, 8'h00},
        {2'd2, 4'h0, 16'h4011, 8'h00, 8'h04}, // R6 alarm
        {2'd3, 4'h0, 16'h0000, 8'h00, 8'h00}, // R5
        {2'd1, 4'h0, 16'h4019, 8'h08, 8'h00},
        {2'd3, 4'h0, 16'h0000, 8'h00, 8'h01}, // R6
        {2'd2, 4'h0, 16'h4010, 8'h00, 8'h01}, // R8
        {2'd0, 4'hC, 16'h0000, 8'h00, 8'h00},
        {2'd2, 4'h0, 16'h4011, 8'h00, 8'h0C}, // R6 periodic
        {2'd1, 4'h0, 16'h4011, 8'hFF, 8'h00},
        {2'd2, 4'h0, 16'h4011, 8'h00, 8'h00}, // R2 / R9
        {2'd1, 4'h0, 16'h4019, 8'hFF, 8'h00},
        {2'd2, 4'h0, 16'h4019, 8'h00, 8'h0C}, // R9 mask width
        {2'd2, 4'h0, 16'h4000, 8'h00, 8'h00}, // R9 unmapped
        {2'd3, 4'h0, 16'h0000, 8'h00, 8'h00}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_in = 4'h0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        irq_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2);
        check("R4 reset irq", {7'b0, irq_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            unique case (v[37:36])
                2'd0: begin
                    src_in = v[35:32];
                    repeat (4) @(negedge clk);
                end
                2'd1: wr(v[31:16], v[15:8]);
                2'd2: rd("R-table read", v[31:16], v[7:0]);
                default: check("R-table irq", {7'b0, irq_out}, v[7:0]);
            endcase
        end

        // R9: rdata is zero with rd_en low
        addr = 16'h401A; rd_en = 1'b0; #1;
        check("R9 idle rdata", rdata, 8'h00);

        // R10: exact latency on sink 2
        src_in = 4'h0;
        repeat (4) @(negedge clk);
        @(negedge clk);
        src_in = 4'h2;
        @(negedge clk);
        @(negedge clk);
        rd("R10 not yet", 16'h4012, 8'h00);
        @(negedge clk);
        rd("R10 set", 16'h4012, 8'h80);

        // R3: clear meets a new edge in the same cycle
        @(negedge clk);
        src_in = 4'h0;
        repeat (4) @(negedge clk);
        src_in = 4'h2;
        @(negedge clk);
        @(negedge clk);
        addr = 16'h4012; wdata = 8'h80; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd("R3 set wins", 16'h4012, 8'h80);
        wr(16'h4012, 8'h80);
        rd("R2 clear after", 16'h4012, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule